// File: doc/BRIEF.md
# Memory-Mapped I/O Range Router

This block decides where a 40-bit memory-mapped I/O request goes. Software programs eight windows. Each window is a pair of 32-bit words. The base word holds the start of the window and its access controls. The limit word holds the end of the window and the routing target: a destination node, a destination link and a flag that forces writes to be non-posted. A lookup compares the request address against every window in parallel. The lowest-numbered window that accepts the request supplies the route. The result comes back one clock later as a registered response.

Lookups use a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response is held on the response pins until it is taken on an edge where `resp_valid` and `resp_ready` are both high. While a response is stalled, `req_ready` stays low, so back-pressure passes straight from the response side to the request side. Nothing is dropped and nothing is duplicated. The register port is a plain word-indexed interface. Reads are combinational. A write takes effect on the clock edge. Setting a window's lock bit freezes both words of that window until reset.

Top module: `mr_router`

## Requirements
- R1: After reset, all 16 register words read 0, `resp_valid` is 0, `req_ready` is 1 and `cfg_err` is 0. Reset is the only thing that clears a lock.
- R2: `cfg_addr` selects a word as {window index, word select}, where word select 0 is the base word and 1 is the limit word. Reserved bits are stored as 0, so a base word reads back as written AND 0xFFFFFF0F and a limit word reads back as written AND 0xFFFFFFB7.
- R3: Bits 31:8 of both words hold request address bits 39:16. A window matches when address bits 39:16 lie between the base field and the limit field, with both bounds included.
- R4: Base bit 0 enables the window for reads and base bit 1 enables it for writes (`req_write`=1). A window whose enable for the request's direction is 0 does not hit.
- R5: If base bit 2 is set, the window never hits for a request with `req_cpu`=1.
- R6: Limit bits 2:0 give the node and limit bits 5:4 give the link. A window whose link code is 3 (reserved) never hits.
- R7: When several windows hit, the window with the lowest index supplies the node, link and non-posted flag.
- R8: `resp_np` equals limit bit 7 of the winning window for a write that hits. It is 0 for reads and for misses.
- R9: Base bit 3 locks the window. While a window is locked, writes to either of its words are ignored and `cfg_err` is 1 for exactly the cycle after that write. Writes to an unlocked window leave `cfg_err` at 0. The write that sets the lock is itself accepted.
- R10: `req_ready` = !`resp_valid` || `resp_ready`. A request accepted on one edge appears with `resp_valid`=1 after that edge. A response stays stable while it is stalled.
- R11: On a miss, `resp_hit`, `resp_node`, `resp_link` and `resp_np` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Word index {window, select} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the addressed word (combinational) |
| cfg_err | output | 1 | One-cycle pulse after a write to a locked window |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 40 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 1 | Request comes from the CPU |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_hit | output | 1 | A window matched |
| resp_node | output | 3 | Destination node |
| resp_link | output | 2 | Destination link |
| resp_np | output | 1 | Write must be non-posted |

## Verification
The assertions assume two things about the environment. First, `resp_ready` is a free-running consumer signal. Second, configuration writes do not race a lookup in a way that changes a held response, because the response is registered and does not depend on register contents after capture. The hold property relies on the block never changing a stalled response by itself. The stimulus therefore writes registers only while no response is outstanding, drops `req_valid` after each accepted lookup except in the deliberate back-pressure scenario, and lowers `resp_ready` only when it means to test stalling.

// File: rtl/mr_pkg.sv
package mr_pkg;
  localparam int ADDR_W  = 40;
  localparam int GRAN_W  = 16;
  localparam int FLD_W   = ADDR_W - GRAN_W;
  localparam int FLD_LSB = 8;
  localparam int WORD_W  = 32;

  // base word bit positions
  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_CPUX = 2;
  localparam int B_LOCK = 3;
  // limit word bit positions
  localparam int L_NODE = 0;
  localparam int L_LINK = 4;
  localparam int L_NP   = 7;

  localparam logic [WORD_W-1:0] BASE_MASK = 32'hFFFF_FF0F;
  localparam logic [WORD_W-1:0] LIM_MASK  = 32'hFFFF_FFB7;
  localparam logic [1:0]        LINK_RSVD = 2'b11;

  typedef struct packed {
    logic       hit;
    logic [2:0] node;
    logic [1:0] link;
    logic       np;
  } route_t;
endpackage

// File: rtl/mr_regs.sv
module mr_regs
  import mr_pkg::*;
#(
  parameter int NPAIR = 8,
  localparam int IDX_W = $clog2(NPAIR)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W:0]               cfg_addr,
  input  logic [WORD_W-1:0]            cfg_wdata,
  output logic [WORD_W-1:0]            cfg_rdata,
  output logic                         cfg_err,
  output logic [NPAIR-1:0][WORD_W-1:0] base_o,
  output logic [NPAIR-1:0][WORD_W-1:0] lim_o
);
  logic [IDX_W-1:0] pick;
  logic             is_lim;
  logic             err_q;

  assign pick   = cfg_addr[IDX_W:1];
  assign is_lim = cfg_addr[0];

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic [WORD_W-1:0] base_q, lim_q;
    logic              wr_here;

    assign wr_here = cfg_we && (pick == IDX_W'(i)) && !base_q[B_LOCK];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        lim_q  <= '0;
      end else if (wr_here) begin
        if (is_lim) lim_q  <= cfg_wdata & LIM_MASK;
        else        base_q <= cfg_wdata & BASE_MASK;
      end
    end

    assign base_o[i] = base_q;
    assign lim_o[i]  = lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cfg_we && base_o[pick][B_LOCK];
  end

  assign cfg_err   = err_q;
  assign cfg_rdata = is_lim ? lim_o[pick] : base_o[pick];
endmodule

// File: rtl/mr_cmp.sv
module mr_cmp
  import mr_pkg::*;
(
  input  logic [WORD_W-1:0] base_w,
  input  logic [WORD_W-1:0] lim_w,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              from_cpu,
  output logic              hit
);
  logic [FLD_W-1:0] a_fld, lo, hi;
  logic             dir_ok, cpu_ok, link_ok, in_rng;

  assign a_fld   = addr[ADDR_W-1:GRAN_W];
  assign lo      = base_w[FLD_LSB +: FLD_W];
  assign hi      = lim_w[FLD_LSB +: FLD_W];
  assign dir_ok  = is_write ? base_w[B_WR] : base_w[B_RD];
  assign cpu_ok  = !(from_cpu && base_w[B_CPUX]);
  assign link_ok = lim_w[L_LINK +: 2] != LINK_RSVD;
  assign in_rng  = (a_fld >= lo) && (a_fld <= hi);
  assign hit     = dir_ok && cpu_ok && link_ok && in_rng;
endmodule

// File: rtl/mr_prio.sv
module mr_prio
  import mr_pkg::*;
#(
  parameter int NPAIR = 8
) (
  input  logic [NPAIR-1:0]             hits,
  input  logic [NPAIR-1:0][WORD_W-1:0] lim_w,
  input  logic                         is_write,
  output route_t                       route
);
  always_comb begin
    route = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (hits[i]) begin
        route.hit  = 1'b1;
        route.node = lim_w[i][L_NODE +: 3];
        route.link = lim_w[i][L_LINK +: 2];
        route.np   = is_write && lim_w[i][L_NP];
      end
    end
  end
endmodule

// File: rtl/mr_router.sv
module mr_router
  import mr_pkg::*;
#(
  parameter int NPAIR = 8,
  localparam int IDX_W = $clog2(NPAIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W:0]    cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [39:0]       req_addr,
  input  logic              req_write,
  input  logic              req_cpu,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [2:0]        resp_node,
  output logic [1:0]        resp_link,
  output logic              resp_np
);
  logic [NPAIR-1:0][WORD_W-1:0] base_w, lim_w;
  logic [NPAIR-1:0]             hits;
  route_t                       nxt, cur;
  logic                         vld_q;

  mr_regs #(.NPAIR(NPAIR)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata, .cfg_err,
    .base_o(base_w), .lim_o(lim_w)
  );

  for (genvar i = 0; i < NPAIR; i++) begin : g_cmp
    mr_cmp u_cmp (
      .base_w(base_w[i]), .lim_w(lim_w[i]), .addr(req_addr),
      .is_write(req_write), .from_cpu(req_cpu), .hit(hits[i])
    );
  end

  mr_prio #(.NPAIR(NPAIR)) u_prio (
    .hits, .lim_w, .is_write(req_write), .route(nxt)
  );

  assign req_ready = !vld_q || resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cur   <= '0;
    end else if (req_valid && req_ready) begin
      vld_q <= 1'b1;
      cur   <= nxt;
    end else if (resp_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign resp_valid = vld_q;
  assign resp_hit   = cur.hit;
  assign resp_node  = cur.node;
  assign resp_link  = cur.link;
  assign resp_np    = cur.np;
endmodule

// File: rtl/mr_router_chk.sv
module mr_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_err,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic       resp_ready,
  input logic       resp_hit,
  input logic [2:0] resp_node,
  input logic [1:0] resp_link,
  input logic       resp_np
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) &&
      $stable(resp_node) && $stable(resp_link) && $stable(resp_np));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  p_np_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_np |-> resp_hit);

  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> resp_node == 3'd0 && resp_link == 2'd0 && !resp_np);

  p_link_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> resp_link != 2'b11);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
endmodule

bind mr_router mr_router_chk u_chk (
  .clk, .rst_n, .cfg_we, .cfg_err, .req_valid, .req_ready, .resp_valid,
  .resp_ready, .resp_hit, .resp_node, .resp_link, .resp_np
);

// File: tb/sim_mr_router.sv
`timescale 1ns/1ps
module sim_mr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_cpu = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_hit;
  logic [2:0]  resp_node;
  logic [1:0]  resp_link;
  logic        resp_np;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mr_router u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic exp_err, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(tag, cfg_err, exp_err);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic look(input logic [39:0] a, input logic w, input logic cpu,
                      input logic eh, input logic [2:0] en, input logic [1:0] el,
                      input logic enp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_cpu = cpu; resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, resp_valid, 1'b1);
    chk({tag, " route"}, {resp_hit, resp_node, resp_link, resp_np}, {eh, en, el, enp});
  endtask

  task automatic t_reset_r1();
    do_reset();
    for (int i = 0; i < 16; i++) rd(4'(i), 32'h0, "R1 reset word");
    chk("R1 resp_valid", resp_valid, 1'b0);
    chk("R1 req_ready", req_ready, 1'b1);
    chk("R1 cfg_err", cfg_err, 1'b0);
  endtask

  task automatic t_setup_r2();
    wr(4'd1, 32'h0001FF92, 1'b0, "R9 unlocked no err");   // w0: node2 link1 np
    wr(4'd0, 32'h000100F3, 1'b0, "R9 unlocked no err");
    rd(4'd0, 32'h00010003, "R2 base mask");
    rd(4'd1, 32'h0001FF92, "R2 limit");
    wr(4'd3, 32'h0002FF25, 1'b0, "R2 w1 limit");          // w1: node5 link2
    wr(4'd2, 32'h00018005, 1'b0, "R2 w1 base");           // read only, cpu-disable
    wr(4'd5, 32'h0004FF31, 1'b0, "R2 w2 limit");          // w2: reserved link
    wr(4'd4, 32'h00040003, 1'b0, "R2 w2 base");
    wr(4'd15, 32'hFFFFFFFF, 1'b0, "R2 w7 limit");
    rd(4'd15, 32'hFFFFFFB7, "R2 limit mask");
  endtask

  task automatic t_range_r3();
    look(40'h00_0100_0000, 1'b0, 1'b0, 1, 3'd2, 2'd1, 0, "R3 low bound");
    look(40'h00_01FF_FFFF, 1'b0, 1'b0, 1, 3'd2, 2'd1, 0, "R3 high bound");
    look(40'h00_00FF_FFFF, 1'b0, 1'b0, 0, 3'd0, 2'd0, 0, "R3 below R11");
    look(40'h00_0300_0000, 1'b0, 1'b0, 0, 3'd0, 2'd0, 0, "R3 above R11");
  endtask

  task automatic t_gates_r4_r5_r6();
    look(40'h00_0250_0000, 1'b0, 1'b0, 1, 3'd5, 2'd2, 0, "R4 read enabled");
    look(40'h00_0250_0000, 1'b1, 1'b0, 0, 3'd0, 2'd0, 0, "R4 write disabled");
    look(40'h00_0250_0000, 1'b0, 1'b1, 0, 3'd0, 2'd0, 0, "R5 cpu excluded");
    look(40'h00_0410_0000, 1'b0, 1'b0, 0, 3'd0, 2'd0, 0, "R6 reserved link");
  endtask

  task automatic t_prio_r7_r8();
    look(40'h00_0180_0000, 1'b0, 1'b0, 1, 3'd2, 2'd1, 0, "R7 lowest wins");
    look(40'h00_0180_0000, 1'b1, 1'b0, 1, 3'd2, 2'd1, 1, "R8 write np");
    look(40'h00_0150_0000, 1'b0, 1'b1, 1, 3'd2, 2'd1, 0, "R8 read np0");
  endtask

  task automatic t_lock_r9();
    wr(4'd14, 32'hFFFFFFFF, 1'b0, "R9 lock write accepted");
    rd(4'd14, 32'hFFFFFF0F, "R2 base mask all ones");
    wr(4'd15, 32'h0, 1'b1, "R9 locked limit err");
    rd(4'd15, 32'hFFFFFFB7, "R9 limit kept");
    wr(4'd14, 32'h0, 1'b1, "R9 locked base err");
    rd(4'd14, 32'hFFFFFF0F, "R9 base kept");
    @(negedge clk);
    chk("R9 err one cycle", cfg_err, 1'b0);
    wr(4'd7, 32'h0006FF03, 1'b0, "R9 w3 limit");
    wr(4'd6, 32'h0006000B, 1'b0, "R9 w3 lock");
    wr(4'd6, 32'h0, 1'b1, "R9 w3 locked err");
    look(40'h00_0600_0000, 1'b1, 1'b0, 1, 3'd3, 2'd0, 0, "R9 locked still routes");
  endtask

  task automatic t_backpressure_r10();
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 40'h00_0250_0000; req_write = 1'b0; req_cpu = 1'b0;
    @(negedge clk);
    req_addr = 40'h00_0180_0000; req_write = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R10 stalled valid", resp_valid, 1'b1);
      chk("R10 stalled ready", req_ready, 1'b0);
      chk("R10 stalled hold", {resp_hit, resp_node, resp_link, resp_np}, {1'b1, 3'd5, 2'd2, 1'b0});
      @(negedge clk);
    end
    resp_ready = 1'b1;
    #1 chk("R10 ready follows consumer", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next response", {resp_valid, resp_hit, resp_node, resp_link, resp_np},
        {1'b1, 1'b1, 3'd2, 2'd1, 1'b1});
    @(negedge clk);
    chk("R10 drained", resp_valid, 1'b0);
  endtask

  task automatic t_relock_r1();
    do_reset();
    rd(4'd6, 32'h0, "R1 lock cleared by reset");
    wr(4'd6, 32'h00000003, 1'b0, "R1 write after reset no err");
    rd(4'd6, 32'h00000003, "R1 write after reset stored");
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_setup_r2();
    t_range_r3();
    t_gates_r4_r5_r6();
    t_prio_r7_r8();
    t_lock_r9();
    t_backpressure_r10();
    t_relock_r1();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule